// File: doc/BRIEF.md
# Protected Watchdog Timer

This block supervises software running on the chip. It counts ticks of a slow time base, around 32 kHz. If software does not re-arm it before a timeout it selects, the block either requests a system reset or raises a non-maskable interrupt. The timeout is a power of two times a base count of ticks. One prescale code gives an immediate reset instead of a timeout, and the codes above it leave the timer idle.

Software controls the block through one 8-bit control/status register on a simple register bus. A locked write can set only the unlock bit. The next bus write, if it targets the register, loads the other fields. Any write to another target in between drops the unlock. A timeout flag records every expiry. Only software or the hardware reset clears it, so it survives the reset that the watchdog itself requests.

In interrupt mode the counter restarts after each expiry, so the block also serves as a periodic timer. The interrupt request stays high until it is acknowledged. A power-monitor event disables the watchdog.

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` is low at a clock edge, the register reads 0x10. This is prescale 1 with every other bit 0. `wd_rst_req` and `wd_irq` are low.
- R2: Register layout: bits [7:4] are the prescale code, bit 3 selects interrupt mode, bit 2 is the timeout flag, bit 1 is enable and bit 0 is unlock. While unlock is 0, a register write changes only the unlock bit, which takes `bus_wdata[0]`. Bits [7:1] keep their values.
- R3: While unlock is 1, the next register write loads bits [7:3] and enable from `bus_wdata`, and clears unlock. A bus write with `bus_sel` low clears unlock instead, and a register write that follows it is treated as locked.
- R4: An accepted write with enable at 1 clears the counter. With prescale P from 0 to MAX_PRE, the watchdog expires on exactly the 2^(BASE_LOG2+P)-th tick after that write, unless another accepted write comes first.
- R5: In reset mode (bit 3 = 0), an expiry drives `wd_rst_req` high for exactly one clock cycle, starting in the cycle after the expiring tick. The same expiry clears enable and sets the timeout flag.
- R6: In interrupt mode (bit 3 = 1), an expiry sets `wd_irq`, which holds until `wd_irq_ack` is high at a clock edge. Enable stays 1 and the counter restarts, so expiries repeat every timeout period.
- R7: Every expiry sets the timeout flag. An accepted write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. An expiry never clears it.
- R8: With prescale code MAX_PRE+1 (8 by default) and enable at 1, `wd_rst_req` pulses in the cycle after the write, whatever the mode bit holds. Enable is cleared and the flag is set.
- R9: Prescale codes above MAX_PRE+1 keep the counter stopped and raise no reset or interrupt.
- R10: A `pmon_evt` pulse clears enable, so no later expiry happens.
- R11: A hardware reset (`rst_n` low) restores 0x10, clearing a set timeout flag and a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| tick | input | 1 | Single-cycle enable from the slow time base |
| bus_wr | input | 1 | Bus write strobe, for any target |
| bus_sel | input | 1 | High when the bus write targets this register |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Current register contents |
| pmon_evt | input | 1 | Power-monitor event pulse |
| wd_irq_ack | input | 1 | Interrupt acknowledge |
| wd_rst_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | Held non-maskable interrupt request |

## Verification
The bench builds the block with BASE_LOG2 = 2 and MAX_PRE = 7. This keeps the real prescale code map, with the immediate-reset code at 8 and reserved codes above it. The shortest timeout shrinks to 4 ticks and the longest to 512. As a result, the exact expiry tick can be checked at both ends of the prescale range within a short run. Each expected reset pulse and interrupt edge is queued before the stimulus that causes it, so missing, extra and mis-typed events are all caught.

// File: rtl/wdt_pkg.sv
// Package: shared register layout for the protected watchdog.
// Assumes the register is 8 bits wide with a 4-bit prescale field on top.
package wdt_pkg;
    localparam int PRE_W = 4;

    // Control/status register image, MSB first.
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             irq_mode;
        logic             tmo_flag;
        logic             enable;
        logic             unlock;
    } wdt_reg_t;

    localparam logic [PRE_W-1:0] RESET_PRE = 4'd1;
endpackage

// File: rtl/wdt_unlock.sv
// Write gate: tracks the unlock bit and decides whether a register write is
// accepted. Assumes bus_wr is a one-cycle strobe per write.
module wdt_unlock (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_wr,
    input  logic bus_sel,
    input  logic wdata_unlock,
    output logic armed,
    output logic wr_accept
);
    // A write is accepted only while the gate is armed.
    assign wr_accept = bus_wr && bus_sel && armed;

    // Arm on a locked register write with bit 0 set; any other write disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (bus_wr) begin
            if (bus_sel && !armed) begin
                armed <= wdata_unlock;
            end else begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wdt_tick_counter.sv
// Timeout counter: counts slow ticks while running and flags expiry on the
// 2^(BASE_LOG2+pre)-th tick. Assumes pre codes above MAX_PRE mean "stopped".
module wdt_tick_counter #(
    parameter int BASE_LOG2 = 9,
    parameter int MAX_PRE   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     enable,
    input  logic                     clr,
    input  logic [wdt_pkg::PRE_W-1:0] pre,
    output logic                     expire
);
    localparam int CW = BASE_LOG2 + MAX_PRE;

    logic [CW-1:0]             cnt;
    logic [CW:0]               lim_m1;
    logic                      run;
    logic [wdt_pkg::PRE_W-1:0] pre_eff;

    // Running only with enable set and an implemented prescale code.
    assign run     = enable && (int'(pre) <= MAX_PRE);
    assign pre_eff = run ? pre : '0;

    // Terminal count for the selected prescale, one below the period.
    always_comb begin
        lim_m1 = ((CW+1)'(1) << (BASE_LOG2 + int'(pre_eff))) - (CW+1)'(1);
    end

    // Expiry on the tick that completes the period; a clear wins.
    assign expire = run && !clr && tick && ({1'b0, cnt} == lim_m1);

    // Count ticks, restart on clear, stop or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !run || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/wdt_ctrl_reg.sv
// Control/status fields plus the reset and interrupt request outputs.
// Assumes expiry events never coincide with an accepted write (top gates them).
module wdt_ctrl_reg (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_accept,
    input  logic [7:1]                wdata,
    input  logic                      tmo_evt,
    input  logic                      imm_evt,
    input  logic                      pmon_evt,
    input  logic                      irq_ack,
    output logic [wdt_pkg::PRE_W-1:0] pre,
    output logic                      irq_mode,
    output logic                      tmo_flag,
    output logic                      enable,
    output logic                      rst_req,
    output logic                      irq
);
    logic fire_rst;
    logic fire_irq;

    // Classify the event into reset or interrupt response.
    assign fire_rst = imm_evt || (tmo_evt && !irq_mode);
    assign fire_irq = tmo_evt && irq_mode;

    // Register fields: software writes, then event and monitor side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre      <= wdt_pkg::RESET_PRE;
            irq_mode <= 1'b0;
            tmo_flag <= 1'b0;
            enable   <= 1'b0;
        end else begin
            if (wr_accept) begin
                pre      <= wdata[7:4];
                irq_mode <= wdata[3];
                enable   <= wdata[1];
                if (!wdata[2]) begin
                    tmo_flag <= 1'b0;
                end
            end
            if (tmo_evt || imm_evt) begin
                tmo_flag <= 1'b1;
            end
            if (fire_rst || pmon_evt) begin
                enable <= 1'b0;
            end
        end
    end

    // One-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire_rst;
        end
    end

    // Interrupt request held until acknowledged; a new expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (fire_irq) begin
            irq <= 1'b1;
        end else if (irq_ack) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_guard.sv
// Top of the protected watchdog: unlock gate, tick counter and register.
// Assumes tick is synchronous to clk and MAX_PRE+1 fits the 4-bit field.
module wdt_guard #(
    parameter int BASE_LOG2 = 9,
    parameter int MAX_PRE   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pmon_evt,
    input  logic       wd_irq_ack,
    output logic       wd_rst_req,
    output logic       wd_irq
);
    import wdt_pkg::*;

    localparam logic [PRE_W-1:0] IMM_CODE = PRE_W'(MAX_PRE + 1);

    logic             armed;
    logic             wr_accept;
    logic             tmo_evt;
    logic             imm_evt;
    logic [PRE_W-1:0] pre;
    logic             irq_mode;
    logic             tmo_flag;
    logic             enable;
    wdt_reg_t         image;

    wdt_unlock u_unlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_sel      (bus_sel),
        .wdata_unlock (bus_wdata[0]),
        .armed        (armed),
        .wr_accept    (wr_accept)
    );

    wdt_tick_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .MAX_PRE   (MAX_PRE)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .enable (enable),
        .clr    (wr_accept),
        .pre    (pre),
        .expire (tmo_evt)
    );

    // Immediate-reset code fires as soon as it is enabled.
    assign imm_evt = enable && (pre == IMM_CODE) && !wr_accept;

    wdt_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .wdata     (bus_wdata[7:1]),
        .tmo_evt   (tmo_evt),
        .imm_evt   (imm_evt),
        .pmon_evt  (pmon_evt),
        .irq_ack   (wd_irq_ack),
        .pre       (pre),
        .irq_mode  (irq_mode),
        .tmo_flag  (tmo_flag),
        .enable    (enable),
        .rst_req   (wd_rst_req),
        .irq       (wd_irq)
    );

    // Read-back image of the register.
    always_comb begin
        image.pre      = pre;
        image.irq_mode = irq_mode;
        image.tmo_flag = tmo_flag;
        image.enable   = enable;
        image.unlock   = armed;
    end
    assign bus_rdata = image;
endmodule

// File: rtl/wdt_guard_chk.sv
// Checker for wdt_guard: temporal rules on its ports, attached by bind.
module wdt_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_sel,
    input logic [7:0] bus_rdata,
    input logic       wd_irq_ack,
    input logic       wd_rst_req,
    input logic       wd_irq
);
    // R5: reset request lasts one cycle.
    a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |=> !wd_rst_req);

    // R5 / R8: a reset request comes with enable cleared and the flag set.
    a_r5_rst_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> (bus_rdata[2] && !bus_rdata[1]));

    // R6: interrupt holds until acknowledged.
    a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_irq && !wd_irq_ack) |=> wd_irq);

    // R2: a locked register write leaves the upper fields alone.
    a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && !bus_rdata[0]) |=> (bus_rdata[7:3] == $past(bus_rdata[7:3])));

    // R3: a write to another target drops the unlock.
    a_r3_cancel_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel) |=> !bus_rdata[0]);

    // R9: reserved codes never produce a reset request.
    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> (bus_rdata[7:4] <= 4'd8));
endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_rdata  (bus_rdata),
    .wd_irq_ack (wd_irq_ack),
    .wd_rst_req (wd_rst_req),
    .wd_irq     (wd_irq)
);

// File: tb/test_wdt_guard.sv
// Scoreboard bench: the driver queues expected events, the monitor pops them.
module test_wdt_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pmon_evt = 1'b0;
    logic       wd_irq_ack = 1'b0;
    logic       wd_rst_req;
    logic       wd_irq;

    int  n_checks = 0;
    int  n_errors = 0;
    int  exp_q[$];
    bit  prev_rst = 1'b0;
    bit  prev_irq = 1'b0;
    bit  done = 1'b0;

    wdt_guard #(.BASE_LOG2(2), .MAX_PRE(7)) i_wdt_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .bus_wr     (bus_wr),
        .bus_sel    (bus_sel),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pmon_evt   (pmon_evt),
        .wd_irq_ack (wd_irq_ack),
        .wd_rst_req (wd_rst_req),
        .wd_irq     (wd_irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic prot_write(input logic [7:0] d);
        bus_write(1'b1, 8'h01);
        bus_write(1'b1, d);
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 tick = 1'b1;
            @(posedge clk); #1 tick = 1'b0;
        end
    endtask

    task automatic pulse_ack();
        @(posedge clk); #1 wd_irq_ack = 1'b1;
        @(posedge clk); #1 wd_irq_ack = 1'b0;
    endtask

    task automatic check_reg(input logic [7:0] exp, input string req);
        chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    // Monitor: match each reset or interrupt edge against the queue (0 = reset, 1 = irq).
    always @(negedge clk) begin
        int k;
        if (!rst_n) begin
            prev_rst <= 1'b0;
            prev_irq <= 1'b0;
        end else begin
            if (wd_rst_req && prev_rst) chk(1'b0, "R5 reset pulse too long", 1, 0);
            if (wd_rst_req && !prev_rst) begin
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected reset", 0, 1);
                else begin
                    k = exp_q.pop_front();
                    chk(k == 0, "R5 event kind reset", 0, k);
                end
            end
            if (wd_irq && !prev_irq) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected irq", 1, 0);
                else begin
                    k = exp_q.pop_front();
                    chk(k == 1, "R6 event kind irq", 1, k);
                end
            end
            prev_rst <= wd_rst_req;
            prev_irq <= wd_irq;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check_reg(8'h10, "R1 reset value");
        chk(!wd_rst_req && !wd_irq, "R1 outputs low", {wd_rst_req, wd_irq}, 0);

        // R2 locked write with bit0 = 0 changes nothing
        bus_write(1'b1, 8'hF2);
        check_reg(8'h10, "R2 locked write ignored");
        // R3 unlock, then a foreign write cancels it
        bus_write(1'b1, 8'h01);
        check_reg(8'h11, "R2 unlock bit set");
        bus_write(1'b0, 8'hFF);
        check_reg(8'h10, "R3 foreign write cancels unlock");
        bus_write(1'b1, 8'h02);
        check_reg(8'h10, "R3 write after cancel ignored");

        // R4/R5 reset mode, prescale 0: 4 ticks
        prot_write(8'h02);
        check_reg(8'h02, "R3 accepted write");
        do_ticks(3);
        chk(!wd_rst_req, "R4 no expiry before period", wd_rst_req, 0);
        exp_q.push_back(0);
        do_ticks(1);
        chk(wd_rst_req, "R5 reset request on expiry", wd_rst_req, 1);
        @(posedge clk); #1;
        chk(!wd_rst_req, "R5 single cycle", wd_rst_req, 0);
        check_reg(8'h04, "R5 flag set enable cleared");

        // R7 flag kept by bit2 = 1, cleared by bit2 = 0
        prot_write(8'h04);
        check_reg(8'h04, "R7 flag kept on write of 1");
        prot_write(8'h02);
        check_reg(8'h02, "R7 flag cleared on write of 0");
        // R4 re-arm restarts the period
        do_ticks(3);
        prot_write(8'h02);
        do_ticks(3);
        chk(!wd_rst_req, "R4 re-arm restarted counter", wd_rst_req, 0);
        exp_q.push_back(0);
        do_ticks(1);
        chk(wd_rst_req, "R4 expiry after re-arm", wd_rst_req, 1);

        // R6 interrupt mode, periodic, held until ack
        prot_write(8'h0A);
        exp_q.push_back(1);
        do_ticks(4);
        chk(wd_irq, "R6 irq raised", wd_irq, 1);
        check_reg(8'h0E, "R6 enable stays, flag set");
        do_ticks(4);
        chk(wd_irq, "R6 irq held without ack", wd_irq, 1);
        pulse_ack();
        chk(!wd_irq, "R6 irq cleared by ack", wd_irq, 0);
        exp_q.push_back(1);
        do_ticks(4);
        chk(wd_irq, "R6 periodic expiry", wd_irq, 1);
        pulse_ack();

        // R4 prescale 1: 8 ticks
        prot_write(8'h1A);
        do_ticks(7);
        chk(!wd_irq, "R4 prescale 1 not yet", wd_irq, 0);
        exp_q.push_back(1);
        do_ticks(1);
        chk(wd_irq, "R4 prescale 1 expiry", wd_irq, 1);
        pulse_ack();

        // R10 power-monitor event disables
        prot_write(8'h0A);
        @(posedge clk); #1 pmon_evt = 1'b1;
        @(posedge clk); #1 pmon_evt = 1'b0;
        check_reg(8'h08, "R10 enable cleared by pmon");
        do_ticks(8);
        chk(!wd_irq, "R10 no expiry after pmon", wd_irq, 0);

        // R9 reserved prescale: stopped
        prot_write(8'h92);
        do_ticks(20);
        chk(!wd_rst_req && !wd_irq, "R9 reserved code quiet", {wd_rst_req, wd_irq}, 0);
        check_reg(8'h92, "R9 register holds reserved code");

        // R8 immediate reset code, even with interrupt mode set
        prot_write(8'h8A);
        exp_q.push_back(0);
        @(posedge clk); #1;
        chk(wd_rst_req, "R8 immediate reset", wd_rst_req, 1);
        check_reg(8'h8C, "R8 enable cleared, flag set");

        // R4 longest prescale: 512 ticks
        prot_write(8'h72);
        do_ticks(511);
        chk(!wd_rst_req, "R4 prescale 7 not yet", wd_rst_req, 0);
        exp_q.push_back(0);
        do_ticks(1);
        chk(wd_rst_req, "R4 prescale 7 expiry", wd_rst_req, 1);
        @(posedge clk); #1;
        check_reg(8'h74, "R7 flag survives watchdog reset");

        // R11 hardware reset clears flag and pending irq
        prot_write(8'h0A);
        exp_q.push_back(1);
        do_ticks(4);
        chk(wd_irq, "R11 irq pending before reset", wd_irq, 1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1;
        check_reg(8'h10, "R11 default restored");
        chk(!wd_irq, "R11 irq cleared", wd_irq, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;

        chk(exp_q.size() == 0, "R6 all queued events seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule